// File: doc/BRIEF.md
# Descending Stack Engine

This block keeps a last-in, first-out stack in a private word memory of `DEPTH` entries, tracked by its own stack-pointer register. The pointer starts at the highest address and moves downward as words are added. The surrounding core hands it one command at a time: push, pop or reinitialise. A push takes its operand either from a register value on the command bus or from the instruction word that follows the push. In the second case the block raises a fetch request for one cycle, and the core advances its program counter and returns that word. A pop reads the word under the pointer and presents it for write-back.

Overflow and underflow are caught before the memory is touched, and they set sticky error flags. A reinitialise command clears both flags, writes zero to every memory word and then returns the pointer to the top address. Each command signals completion with a single-cycle `done` pulse.

Top module: `stack_unit`

## Requirements
- R1: After reset, `stackPtr` is DEPTH-1 (1023 by default), `empty` is 1, `full` is 0, `ovfErr` and `udfErr` are 0, `busy` is 0 and `popData` is 0.
- R2: A push (`cmdOp` = 2'b00) with `srcImm` = 0 decrements the pointer at acceptance and writes `regData` at the new pointer; `done` rises one cycle after acceptance.
- R3: A push with `srcImm` = 1 holds `fetchReq` high for exactly one cycle. The word on `fetchWord` in that cycle is the value stored, and `done` rises two cycles after acceptance.
- R4: A pop (`cmdOp` = 2'b01) on a non-empty stack puts the memory word at the current pointer on `popData`, not the pointer itself, and increments the pointer; `done` rises one cycle after acceptance.
- R5: Words come back in reverse order of pushing, whatever their source.
- R6: A pop while the pointer is DEPTH-1 sets the sticky `udfErr` and leaves the pointer unchanged; `done` is high in the cycle right after acceptance.
- R7: A push while the pointer is 0 sets the sticky `ovfErr`, writes nothing and leaves the pointer unchanged. A register push completes in the cycle right after acceptance. An immediate push still consumes its word with one `fetchReq` cycle and completes one cycle later.
- R8: A reinitialise (`cmdOp` = 2'b10) clears both error flags, writes zero to every memory word, one word per cycle, and then sets the pointer to DEPTH-1; `done` rises DEPTH cycles after acceptance.
- R9: `done` is high for a single cycle per command; it is not high in two consecutive cycles unless a new command was accepted in the first of them.
- R10: `empty` is 1 exactly when the pointer is DEPTH-1 and `full` is 1 exactly when it is 0. `busy` is high while a command is in progress, and a command offered while `busy` is high is ignored. `cmdOp` = 2'b11 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered this cycle (taken only when `busy` is 0) |
| cmdOp | input | 2 | 00 push, 01 pop, 10 reinitialise, 11 none |
| srcImm | input | 1 | Push source: 0 register value, 1 following instruction word |
| regData | input | DATA_W | Register operand for a push |
| fetchReq | output | 1 | Request to advance the program counter and supply the next word |
| fetchWord | input | DATA_W | Instruction word returned while `fetchReq` is high |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| popData | output | DATA_W | Word returned by the last successful pop |
| stackPtr | output | ADDR_W | Current stack pointer |
| empty | output | 1 | Pointer at the top address |
| full | output | 1 | Pointer at address 0 |
| ovfErr | output | 1 | Sticky overflow flag |
| udfErr | output | 1 | Sticky underflow flag |

## Verification
The bench fills the stack until the pointer reaches zero, then pushes again from both sources. A design that wrote anyway would show a changed word on the next pop. A design that skipped the fetch for a rejected immediate push would show a missing `fetchReq` pulse. A pop on an empty stack must leave the pointer at the top, where a wrap would move it to zero. A pop must return memory contents rather than the pointer value. LIFO order is checked across mixed register and immediate pushes, which exposes a post-decrement or a write at the old pointer. Reinitialise latency is counted to the cycle and a push is offered mid-sweep, so a design that accepted commands while busy, or that did not clear the flags, gives the wrong pointer or flags.

// File: rtl/stack_pkg.sv
package stack_pkg;

  localparam logic [1:0] OP_PUSH = 2'b00;
  localparam logic [1:0] OP_POP  = 2'b01;
  localparam logic [1:0] OP_INIT = 2'b10;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_WRITE,
    S_READ,
    S_WIPE
  } ctrl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capReg;
    logic capImm;
    logic decPtr;
    logic incPtr;
    logic wrMem;
    logic rdMem;
    logic wipe;
    logic rstPtr;
    logic raiseOvf;
    logic raiseUdf;
    logic clearFlags;
  } stack_strb_t;

endpackage

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  input  logic        srcImm,
  input  logic        isFull,
  input  logic        isEmpty,
  input  logic        wipeLast,
  output stack_strb_t strb,
  output logic        fetchReq,
  output logic        busy,
  output logic        done
);

  ctrl_state_e state, nState;
  logic        skipWr, nSkip;
  logic        nDone;

  always_comb begin
    strb   = '0;
    nState = state;
    nSkip  = skipWr;
    nDone  = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (cmdValid) begin
          case (cmdOp)
            OP_PUSH: begin
              if (isFull) begin
                strb.raiseOvf = 1'b1;
                if (srcImm) begin
                  nSkip  = 1'b1;
                  nState = S_FETCH;
                end else begin
                  nDone = 1'b1;
                end
              end else begin
                strb.decPtr = 1'b1;
                nSkip       = 1'b0;
                if (srcImm) begin
                  nState = S_FETCH;
                end else begin
                  strb.capReg = 1'b1;
                  nState      = S_WRITE;
                end
              end
            end
            OP_POP: begin
              if (isEmpty) begin
                strb.raiseUdf = 1'b1;
                nDone         = 1'b1;
              end else begin
                nState = S_READ;
              end
            end
            OP_INIT: begin
              strb.clearFlags = 1'b1;
              nState          = S_WIPE;
            end
            default: ;
          endcase
        end
      end
      S_FETCH: begin
        if (skipWr) begin
          nDone  = 1'b1;
          nState = S_IDLE;
        end else begin
          strb.capImm = 1'b1;
          nState      = S_WRITE;
        end
      end
      S_WRITE: begin
        strb.wrMem = 1'b1;
        nDone      = 1'b1;
        nState     = S_IDLE;
      end
      S_READ: begin
        strb.rdMem  = 1'b1;
        strb.incPtr = 1'b1;
        nDone       = 1'b1;
        nState      = S_IDLE;
      end
      S_WIPE: begin
        strb.wipe = 1'b1;
        if (wipeLast) begin
          strb.rstPtr = 1'b1;
          nDone       = 1'b1;
          nState      = S_IDLE;
        end
      end
      default: nState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      skipWr <= 1'b0;
      done   <= 1'b0;
    end else begin
      state  <= nState;
      skipWr <= nSkip;
      done   <= nDone;
    end
  end

  assign fetchReq = (state == S_FETCH);
  assign busy     = (state != S_IDLE);

endmodule

// File: rtl/stack_dp.sv
module stack_dp
  import stack_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  stack_strb_t       strb,
  input  logic [DATA_W-1:0] regData,
  input  logic [DATA_W-1:0] fetchWord,
  output logic [DATA_W-1:0] popData,
  output logic [ADDR_W-1:0] stackPtr,
  output logic              isFull,
  output logic              isEmpty,
  output logic              wipeLast,
  output logic              ovfErr,
  output logic              udfErr
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] pushVal;
  logic [ADDR_W-1:0] wipeAddr;
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;
  logic              wrEn;

  assign isFull   = (stackPtr == '0);
  assign isEmpty  = (stackPtr == TOP_ADDR);
  assign wipeLast = (wipeAddr == TOP_ADDR);

  assign wrEn   = strb.wrMem | strb.wipe;
  assign wrAddr = strb.wipe ? wipeAddr : stackPtr;
  assign wrData = strb.wipe ? '0 : pushVal;

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stackPtr <= TOP_ADDR;
      pushVal  <= '0;
      popData  <= '0;
      wipeAddr <= '0;
      ovfErr   <= 1'b0;
      udfErr   <= 1'b0;
    end else begin
      if (strb.capReg) pushVal <= regData;
      if (strb.capImm) pushVal <= fetchWord;
      if (strb.rdMem)  popData <= mem[stackPtr];
      if (strb.rstPtr)      stackPtr <= TOP_ADDR;
      else if (strb.decPtr) stackPtr <= stackPtr - 1'b1;
      else if (strb.incPtr) stackPtr <= stackPtr + 1'b1;
      if (strb.clearFlags) begin
        ovfErr   <= 1'b0;
        udfErr   <= 1'b0;
        wipeAddr <= '0;
      end else begin
        if (strb.raiseOvf) ovfErr <= 1'b1;
        if (strb.raiseUdf) udfErr <= 1'b1;
        if (strb.wipe)     wipeAddr <= wipeAddr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/stack_unit.sv
module stack_unit
  import stack_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic              srcImm,
  input  logic [DATA_W-1:0] regData,
  output logic              fetchReq,
  input  logic [DATA_W-1:0] fetchWord,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] popData,
  output logic [ADDR_W-1:0] stackPtr,
  output logic              empty,
  output logic              full,
  output logic              ovfErr,
  output logic              udfErr
);

  stack_strb_t strb;
  logic        wipeLast;

  stack_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .srcImm   (srcImm),
    .isFull   (full),
    .isEmpty  (empty),
    .wipeLast (wipeLast),
    .strb     (strb),
    .fetchReq (fetchReq),
    .busy     (busy),
    .done     (done)
  );

  stack_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regData   (regData),
    .fetchWord (fetchWord),
    .popData   (popData),
    .stackPtr  (stackPtr),
    .isFull    (full),
    .isEmpty   (empty),
    .wipeLast  (wipeLast),
    .ovfErr    (ovfErr),
    .udfErr    (udfErr)
  );

endmodule

// File: rtl/stack_unit_chk.sv
module stack_unit_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              busy,
  input logic              done,
  input logic              fetchReq,
  input logic [ADDR_W-1:0] stackPtr,
  input logic              empty,
  input logic              full,
  input logic              ovfErr,
  input logic              udfErr
);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !cmdValid) |=> !done);

  // R6
  udf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(udfErr) |-> $stable(stackPtr));

  // R7
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfErr) |-> $stable(stackPtr));

  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));

  // R3
  fetch_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> busy);

  // R3
  fetch_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |=> !fetchReq);

  // R10
  idle_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind stack_unit stack_unit_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .busy     (busy),
  .done     (done),
  .fetchReq (fetchReq),
  .stackPtr (stackPtr),
  .empty    (empty),
  .full     (full),
  .ovfErr   (ovfErr),
  .udfErr   (udfErr)
);

// File: tb/stack_unit_tb_top.sv
module stack_unit_tb_top;

  localparam int DEPTH = 1024;
  localparam int TOP   = DEPTH - 1;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdValid;
  logic [1:0]  cmdOp;
  logic        srcImm;
  logic [31:0] regData;
  logic        fetchReq;
  logic [31:0] fetchWord;
  logic        busy;
  logic        done;
  logic [31:0] popData;
  logic [9:0]  stackPtr;
  logic        empty;
  logic        full;
  logic        ovfErr;
  logic        udfErr;

  int checks  = 0;
  int fails   = 0;
  int fetches = 0;

  always #10 clk = ~clk;

  stack_unit dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .srcImm(srcImm),
    .regData(regData), .fetchReq(fetchReq), .fetchWord(fetchWord), .busy(busy),
    .done(done), .popData(popData), .stackPtr(stackPtr), .empty(empty), .full(full),
    .ovfErr(ovfErr), .udfErr(udfErr)
  );

  always @(posedge clk) if (fetchReq) fetches++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // offer one command, return the number of edges after acceptance until done
  task automatic doOp(input logic [1:0] op, input logic src, input logic [31:0] val,
                      output int lat);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; srcImm = src; regData = val;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    lat = 0;
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic testReset();
    chk("R1 ptr", 32'(stackPtr), TOP);
    chk("R1 empty", 32'(empty), 1);
    chk("R1 full", 32'(full), 0);
    chk("R1 flags", {30'd0, ovfErr, udfErr}, 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 popData", popData, 0);
  endtask

  task automatic testUnderflow();
    int lat;
    doOp(2'b01, 1'b0, 0, lat);
    chk("R6 latency", lat, 0);
    chk("R6 udfErr", 32'(udfErr), 1);
    chk("R6 ptr held", 32'(stackPtr), TOP);
    @(negedge clk);
    chk("R9 done drops", 32'(done), 0);
    chk("R6 sticky", 32'(udfErr), 1);
  endtask

  task automatic testRegPushPop();
    int lat;
    doOp(2'b00, 1'b0, 32'hCAFE_0001, lat);
    chk("R2 latency", lat, 1);
    chk("R2 ptr", 32'(stackPtr), TOP - 1);
    chk("R10 not empty", 32'(empty), 0);
    @(negedge clk);
    chk("R9 done pulse", 32'(done), 0);
    doOp(2'b01, 1'b0, 0, lat);
    chk("R4 latency", lat, 1);
    chk("R4 data", popData, 32'hCAFE_0001);
    chk("R4 ptr", 32'(stackPtr), TOP);
    doOp(2'b11, 1'b0, 0, lat);
    chk("R10 noop ptr", 32'(stackPtr), TOP);
  endtask

  task automatic testImmPush();
    int lat;
    int f0;
    f0 = fetches;
    fetchWord = 32'h1234_5678;
    doOp(2'b00, 1'b1, 32'hDEAD_DEAD, lat);
    chk("R3 latency", lat, 2);
    chk("R3 one fetch", fetches - f0, 1);
    chk("R3 ptr", 32'(stackPtr), TOP - 1);
    doOp(2'b01, 1'b0, 0, lat);
    chk("R3 stored word", popData, 32'h1234_5678);
  endtask

  task automatic testLifo();
    int lat;
    doOp(2'b00, 1'b0, 32'hA, lat);
    fetchWord = 32'hB;
    doOp(2'b00, 1'b1, 0, lat);
    doOp(2'b00, 1'b0, 32'hC, lat);
    doOp(2'b01, 1'b0, 0, lat);
    chk("R5 first pop", popData, 32'hC);
    doOp(2'b01, 1'b0, 0, lat);
    chk("R5 second pop", popData, 32'hB);
    doOp(2'b01, 1'b0, 0, lat);
    chk("R5 third pop", popData, 32'hA);
    chk("R5 ptr back", 32'(stackPtr), TOP);
  endtask

  task automatic testOverflow();
    int lat;
    int f0;
    for (int i = 0; i < TOP; i++) doOp(2'b00, 1'b0, 32'h1000 + i, lat);
    chk("R10 full", 32'(full), 1);
    chk("R10 ptr zero", 32'(stackPtr), 0);
    doOp(2'b00, 1'b0, 32'hBAD0, lat);
    chk("R7 reg latency", lat, 0);
    chk("R7 ovfErr", 32'(ovfErr), 1);
    chk("R7 ptr held", 32'(stackPtr), 0);
    f0 = fetches;
    fetchWord = 32'hBAD1;
    doOp(2'b00, 1'b1, 0, lat);
    chk("R7 imm latency", lat, 1);
    chk("R7 imm consumed", fetches - f0, 1);
    chk("R7 imm ptr held", 32'(stackPtr), 0);
    doOp(2'b01, 1'b0, 0, lat);
    chk("R7 no write", popData, 32'h1000 + TOP - 1);
    chk("R7 sticky", 32'(ovfErr), 1);
  endtask

  task automatic testInit();
    int lat;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'b10; srcImm = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R8 flags cleared", {30'd0, ovfErr, udfErr}, 0);
    chk("R10 busy", 32'(busy), 1);
    lat = 0;
    while (!done && lat < 5000) begin
      if (lat == 5) begin
        cmdValid = 1'b1; cmdOp = 2'b00; srcImm = 1'b0; regData = 32'h77;
      end else begin
        cmdValid = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    cmdValid = 1'b0;
    chk("R8 latency", lat, DEPTH);
    chk("R8 ptr top", 32'(stackPtr), TOP);
    chk("R10 busy push ignored", 32'(empty), 1);
    chk("R8 flags after", {30'd0, ovfErr, udfErr}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = 2'b11; srcImm = 1'b0;
    regData = '0; fetchWord = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUnderflow();
    testRegPushPop();
    testImmPush();
    testLifo();
    testOverflow();
    testInit();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule